// File: doc/BRIEF.md
# Coprocessor Control and Error Register Bank

This block is the software-visible control plane of a small vector rendering coprocessor. A host reaches it over a plain 32-bit register bus with a write strobe, a byte address and a combinational read path. It holds the run enable, the error-capture mask, the interrupt enable, the page-bound window, the plane mask, an 8-bit raster-op code, a diagnostics word and a read-only identification word.

The execution core feeds the block with several signals:
- per-cause error pulses;
- a register-file write strobe with its register index;
- a memory-write pulse;
- live busy and queue-empty levels.

From these the block keeps sticky flags and drives the interrupt and run-enable outputs. A write to the soft-reset offset stops the engine and clears the event state without touching the software setup.

The register set appears a second time with the top address bit set. In that copy the page-bound window cannot be written.

Top module: `cop_ctrl_regs`

## Requirements
- R1: After rst_ni is released, reads return these values and the outputs are low:
  - control word: only bit 14 and bit 15, which follow their inputs;
  - error word and raster-op word: 0;
  - diagnostics word: DIAG_RST (0x4804);
  - identification word at 0x28: ARCH_ID in bits 1:0 and CHIP_REV in bits 7:3.
- R2: These registers hold what was last written:
  - 0x08 and 0x0C, page bounds low and high, 32 bits each;
  - 0x10, plane mask, 32 bits;
  - 0x14, raster-op code, 8 bits; bits 31:8 read 0;
  - 0x1C, diagnostics, 32 bits;
  - 0x00, control word, in its writable bits: 5:0 capture mask, 7 interrupt enable, 10 page-bound check enable, 12 run. run_o follows bit 12.
- R3: Control bit 14 reads q_empty_i and bit 15 reads busy_i in the same cycle.
- R4: An err_evt_i[k] pulse sets error-word bit k (k = 0..5) when control bit k is 1, and the bit then stays set. When control bit k is 0 the pulse is ignored.
- R5: Writing 1 to error-word bit k clears it. An err_evt_i[k] capture in the same cycle wins over the clear.
- R6: irq_o is high exactly when control bit 7 is 1 and any error-word bit 5:0 is set. Error-word bit 7 reads irq_o.
- R7: A reg_wr_i strobe with index i sets control bit 16 + i / REGS_PER_BANK, the flag of the bank that holds register i.
- R8: Writing 1 to a bank flag in the control word clears it. A reg_wr_i set of the same flag in the same cycle wins.
- R9: A mem_wr_i pulse sets control bit 11. Writing 1 to control bit 11 clears it.
- R10: Addresses with bit 12 set reach the same registers as those with bit 12 clear, for both reads and writes. The exception is writes to 0x1008 and 0x100C, which leave the page bounds unchanged.
- R11: Any write to 0x30 has these effects, and 0x30 reads 0:
  - clears run, the error word, the bank flags and bit 11;
  - reloads diagnostics with DIAG_RST;
  - keeps the capture mask, interrupt enable, page-bound enable, bounds, plane mask and raster-op code.
- R12: Writes to the identification word are ignored, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address, top bit selects the mirror copy |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| err_evt_i | input | 6 | Error cause pulses from the core |
| reg_wr_i | input | 1 | Register-file write strobe from the core |
| reg_idx_i | input | IDX_W | Index of the register being written |
| busy_i | input | 1 | Core executing or instruction pending |
| q_empty_i | input | 1 | Instruction queue empty |
| mem_wr_i | input | 1 | Core wrote memory |
| irq_o | output | 1 | Error interrupt |
| run_o | output | 1 | Run enable to the core |

## Verification
The bench builds the block with these parameters:
- REGS_PER_BANK = 8 and four banks, so IDX_W is 5. Indices 7, 9, 10 and 31 then land in banks 0, 1, 1 and 3, and every bank edge is within a few index values.
- ARCH_ID = 2 and CHIP_REV = 0x13. These non-default values make any mis-placed ID field visible in the identification word (expected 0x9A).

The run also covers the mirror copy at bit 12 and the same-cycle races between hardware sets and write-one-to-clear. It closes with a soft reset issued over a fully dirtied state.

// File: rtl/cop_ctrl_pkg.sv
package cop_ctrl_pkg;
  localparam int OFF_W   = 12;
  localparam int NUM_ERR = 6;

  localparam logic [OFF_W-1:0] OFF_CTRL  = 12'h000;
  localparam logic [OFF_W-1:0] OFF_ERR   = 12'h004;
  localparam logic [OFF_W-1:0] OFF_PB_LO = 12'h008;
  localparam logic [OFF_W-1:0] OFF_PB_HI = 12'h00C;
  localparam logic [OFF_W-1:0] OFF_PMASK = 12'h010;
  localparam logic [OFF_W-1:0] OFF_ROP   = 12'h014;
  localparam logic [OFF_W-1:0] OFF_DIAG  = 12'h01C;
  localparam logic [OFF_W-1:0] OFF_ID    = 12'h028;
  localparam logic [OFF_W-1:0] OFF_SRST  = 12'h030;

  // control word bit positions
  localparam int B_IE     = 7;
  localparam int B_PB     = 10;
  localparam int B_WROTE  = 11;
  localparam int B_GO     = 12;
  localparam int B_QEMPTY = 14;
  localparam int B_BUSY   = 15;
  localparam int B_BANK0  = 16;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_ERR, SEL_PB_LO, SEL_PB_HI,
    SEL_PMASK, SEL_ROP, SEL_DIAG, SEL_ID, SEL_SRST
  } reg_sel_e;
endpackage

// File: rtl/cop_reg_dec.sv
module cop_reg_dec
  import cop_ctrl_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output reg_sel_e          sel_o,
  output logic              wr_o
);
  localparam int LOW_W = ADDR_W - 1;

  logic [LOW_W-1:0] off;
  logic             mirror;

  assign off    = addr_i[LOW_W-1:0];
  assign mirror = addr_i[ADDR_W-1];

  always_comb begin
    sel_o = SEL_NONE;
    if      (off == LOW_W'(OFF_CTRL))  sel_o = SEL_CTRL;
    else if (off == LOW_W'(OFF_ERR))   sel_o = SEL_ERR;
    else if (off == LOW_W'(OFF_PB_LO)) sel_o = SEL_PB_LO;
    else if (off == LOW_W'(OFF_PB_HI)) sel_o = SEL_PB_HI;
    else if (off == LOW_W'(OFF_PMASK)) sel_o = SEL_PMASK;
    else if (off == LOW_W'(OFF_ROP))   sel_o = SEL_ROP;
    else if (off == LOW_W'(OFF_DIAG))  sel_o = SEL_DIAG;
    else if (off == LOW_W'(OFF_ID))    sel_o = SEL_ID;
    else if (off == LOW_W'(OFF_SRST))  sel_o = SEL_SRST;
  end

  // mirror copy protects the page-bound window
  always_comb begin
    wr_o = we_i && (sel_o != SEL_NONE) && (sel_o != SEL_ID);
    if (mirror && (sel_o == SEL_PB_LO || sel_o == SEL_PB_HI)) wr_o = 1'b0;
  end
endmodule

// File: rtl/cop_sticky_bits.sv
module cop_sticky_bits #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_all_i,
  input  logic [N-1:0] set_i,
  input  logic         w1c_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] q_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    q_o[k] <= 1'b0;
      else if (clr_all_i)             q_o[k] <= 1'b0;
      else if (set_i[k])              q_o[k] <= 1'b1;  // set beats clear
      else if (w1c_i && wdata_i[k])   q_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/cop_bank_hit.sv
module cop_bank_hit #(
  parameter int NUM_BANKS     = 4,
  parameter int REGS_PER_BANK = 32,
  localparam int IDX_W = $clog2(NUM_BANKS * REGS_PER_BANK)
) (
  input  logic                 reg_wr_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_BANKS-1:0] hit_o
);
  localparam int SH = $clog2(REGS_PER_BANK);
  localparam int BW = IDX_W - SH;

  logic [BW-1:0] bank;
  logic          unused_idx_lo;

  assign bank          = idx_i[IDX_W-1:SH];
  assign unused_idx_lo = ^idx_i[SH-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign hit_o[b] = reg_wr_i && (bank == BW'(b));
  end
endmodule

// File: rtl/cop_ctrl_regs.sv
module cop_ctrl_regs
  import cop_ctrl_pkg::*;
#(
  parameter int          ADDR_W        = 13,
  parameter int          NUM_BANKS     = 4,
  parameter int          REGS_PER_BANK = 32,
  parameter logic [1:0]  ARCH_ID       = 2'd1,
  parameter logic [4:0]  CHIP_REV      = 5'd1,
  parameter logic [31:0] DIAG_RST      = 32'h0000_4804,
  localparam int IDX_W = $clog2(NUM_BANKS * REGS_PER_BANK)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_ERR-1:0]  err_evt_i,
  input  logic                reg_wr_i,
  input  logic [IDX_W-1:0]    reg_idx_i,
  input  logic                busy_i,
  input  logic                q_empty_i,
  input  logic                mem_wr_i,
  output logic                irq_o,
  output logic                run_o
);
  reg_sel_e sel;
  logic     wr;
  logic     wr_ctrl, wr_err, wr_pb_lo, wr_pb_hi, wr_pmask, wr_rop, wr_diag, wr_srst;

  logic [NUM_ERR-1:0]   err_en_q, err_q;
  logic                 ie_q, pb_en_q, go_q;
  logic [31:0]          pb_lo_q, pb_hi_q, pmask_q, diag_q;
  logic [7:0]           rop_q;
  logic [NUM_BANKS-1:0] bank_hit, bank_q;
  logic [0:0]           wrote_q;

  cop_reg_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .we_i   (we_i),
    .sel_o  (sel),
    .wr_o   (wr)
  );

  assign wr_ctrl  = wr && (sel == SEL_CTRL);
  assign wr_err   = wr && (sel == SEL_ERR);
  assign wr_pb_lo = wr && (sel == SEL_PB_LO);
  assign wr_pb_hi = wr && (sel == SEL_PB_HI);
  assign wr_pmask = wr && (sel == SEL_PMASK);
  assign wr_rop   = wr && (sel == SEL_ROP);
  assign wr_diag  = wr && (sel == SEL_DIAG);
  assign wr_srst  = wr && (sel == SEL_SRST);

  cop_bank_hit #(.NUM_BANKS(NUM_BANKS), .REGS_PER_BANK(REGS_PER_BANK)) u_hit (
    .reg_wr_i (reg_wr_i),
    .idx_i    (reg_idx_i),
    .hit_o    (bank_hit)
  );

  cop_sticky_bits #(.N(NUM_ERR)) u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (wr_srst),
    .set_i     (err_evt_i & err_en_q),
    .w1c_i     (wr_err),
    .wdata_i   (wdata_i[NUM_ERR-1:0]),
    .q_o       (err_q)
  );

  cop_sticky_bits #(.N(NUM_BANKS)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (wr_srst),
    .set_i     (bank_hit),
    .w1c_i     (wr_ctrl),
    .wdata_i   (wdata_i[B_BANK0 +: NUM_BANKS]),
    .q_o       (bank_q)
  );

  cop_sticky_bits #(.N(1)) u_wrote (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (wr_srst),
    .set_i     (mem_wr_i),
    .w1c_i     (wr_ctrl),
    .wdata_i   (wdata_i[B_WROTE]),
    .q_o       (wrote_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_en_q <= '0;
      ie_q     <= 1'b0;
      pb_en_q  <= 1'b0;
      go_q     <= 1'b0;
    end else if (wr_srst) begin
      go_q     <= 1'b0;
    end else if (wr_ctrl) begin
      err_en_q <= wdata_i[NUM_ERR-1:0];
      ie_q     <= wdata_i[B_IE];
      pb_en_q  <= wdata_i[B_PB];
      go_q     <= wdata_i[B_GO];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pb_lo_q <= '0;
      pb_hi_q <= '0;
      pmask_q <= '0;
      rop_q   <= '0;
    end else begin
      if (wr_pb_lo) pb_lo_q <= wdata_i;
      if (wr_pb_hi) pb_hi_q <= wdata_i;
      if (wr_pmask) pmask_q <= wdata_i;
      if (wr_rop)   rop_q   <= wdata_i[7:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      diag_q <= DIAG_RST;
    else if (wr_srst) diag_q <= DIAG_RST;
    else if (wr_diag) diag_q <= wdata_i;
  end

  assign irq_o = ie_q && (|err_q);
  assign run_o = go_q;

  logic [31:0] ctrl_rd, err_rd, id_rd;

  always_comb begin
    ctrl_rd                        = '0;
    ctrl_rd[NUM_ERR-1:0]           = err_en_q;
    ctrl_rd[B_IE]                  = ie_q;
    ctrl_rd[B_PB]                  = pb_en_q;
    ctrl_rd[B_WROTE]               = wrote_q[0];
    ctrl_rd[B_GO]                  = go_q;
    ctrl_rd[B_QEMPTY]              = q_empty_i;
    ctrl_rd[B_BUSY]                = busy_i;
    ctrl_rd[B_BANK0 +: NUM_BANKS]  = bank_q;

    err_rd                         = '0;
    err_rd[NUM_ERR-1:0]            = err_q;
    err_rd[B_IE]                   = irq_o;

    id_rd                          = '0;
    id_rd[1:0]                     = ARCH_ID;
    id_rd[7:3]                     = CHIP_REV;
  end

  always_comb begin
    case (sel)
      SEL_CTRL:  rdata_o = ctrl_rd;
      SEL_ERR:   rdata_o = err_rd;
      SEL_PB_LO: rdata_o = pb_lo_q;
      SEL_PB_HI: rdata_o = pb_hi_q;
      SEL_PMASK: rdata_o = pmask_q;
      SEL_ROP:   rdata_o = {24'h0, rop_q};
      SEL_DIAG:  rdata_o = diag_q;
      SEL_ID:    rdata_o = id_rd;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cop_ctrl_regs_chk.sv
module cop_ctrl_regs_chk #(
  parameter int          ADDR_W        = 13,
  parameter int          NUM_BANKS     = 4,
  parameter int          REGS_PER_BANK = 32,
  parameter int          NERR          = 6,
  parameter logic [31:0] DIAG_RST      = 32'h0000_4804,
  localparam int IDX_W = $clog2(NUM_BANKS * REGS_PER_BANK)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 reg_wr_i,
  input logic [IDX_W-1:0]     reg_idx_i,
  input logic                 irq_o,
  input logic                 run_o,
  input logic [NERR-1:0]      err_q,
  input logic [NUM_BANKS-1:0] bank_q,
  input logic                 wr_err,
  input logic                 wr_srst,
  input logic [31:0]          diag_q,
  input logic [31:0]          pb_lo_q,
  input logic [31:0]          pb_hi_q
);
  localparam int SH = $clog2(REGS_PER_BANK);
  localparam int BW = IDX_W - SH;

  logic [BW-1:0] hit_bank;
  logic          unused_lo;
  assign hit_bank  = reg_idx_i[IDX_W-1:SH];
  assign unused_lo = ^reg_idx_i[SH-1:0];

  a_r6_irq_needs_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (err_q != '0));

  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_err && !wr_srst) |=> ((err_q & $past(err_q)) == $past(err_q)));

  a_r7_bank_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !wr_srst) |=> bank_q[$past(hit_bank)]);

  a_r11_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_srst |=> (!run_o && err_q == '0 && bank_q == '0 && diag_q == DIAG_RST));

  a_r10_mirror_pb_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[ADDR_W-1]) |=> ($stable(pb_lo_q) && $stable(pb_hi_q)));
endmodule

bind cop_ctrl_regs cop_ctrl_regs_chk #(
  .ADDR_W        (ADDR_W),
  .NUM_BANKS     (NUM_BANKS),
  .REGS_PER_BANK (REGS_PER_BANK),
  .NERR          (cop_ctrl_pkg::NUM_ERR),
  .DIAG_RST      (DIAG_RST)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .reg_wr_i  (reg_wr_i),
  .reg_idx_i (reg_idx_i),
  .irq_o     (irq_o),
  .run_o     (run_o),
  .err_q     (err_q),
  .bank_q    (bank_q),
  .wr_err    (wr_err),
  .wr_srst   (wr_srst),
  .diag_q    (diag_q),
  .pb_lo_q   (pb_lo_q),
  .pb_hi_q   (pb_hi_q)
);

// File: tb/sim_cop_ctrl_regs.sv
module sim_cop_ctrl_regs;
  localparam int ADDR_W = 13;
  localparam int IDX_W  = 5;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [5:0]        err_evt_i = '0;
  logic              reg_wr_i = 1'b0;
  logic [IDX_W-1:0]  reg_idx_i = '0;
  logic              busy_i = 1'b0;
  logic              q_empty_i = 1'b1;
  logic              mem_wr_i = 1'b0;
  logic              irq_o, run_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  cop_ctrl_regs #(
    .ADDR_W(ADDR_W), .NUM_BANKS(4), .REGS_PER_BANK(8),
    .ARCH_ID(2'd2), .CHIP_REV(5'h13), .DIAG_RST(32'h0000_4804)
  ) u0 (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o, .err_evt_i,
    .reg_wr_i, .reg_idx_i, .busy_i, .q_empty_i, .mem_wr_i, .irq_o, .run_o
  );

  typedef struct packed {
    logic [12:0] wa;
    logic [31:0] wd;
    logic [12:0] ra;
    logic [31:0] ex;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{13'h0008, 32'hDEAD_BEEF, 13'h0008, 32'hDEAD_BEEF},  // R2
    '{13'h000C, 32'h1234_5678, 13'h000C, 32'h1234_5678},  // R2
    '{13'h0010, 32'hA5A5_0F0F, 13'h0010, 32'hA5A5_0F0F},  // R2
    '{13'h0014, 32'hFFFF_FF3C, 13'h0014, 32'h0000_003C},  // R2
    '{13'h001C, 32'h0000_1234, 13'h001C, 32'h0000_1234},  // R2
    '{13'h0028, 32'hFFFF_FFFF, 13'h0028, 32'h0000_009A},  // R12
    '{13'h1008, 32'h0000_0000, 13'h0008, 32'hDEAD_BEEF},  // R10
    '{13'h1010, 32'h0000_00FF, 13'h0010, 32'h0000_00FF},  // R10
    '{13'h100C, 32'h0000_0001, 13'h100C, 32'h1234_5678},  // R10
    '{13'h0040, 32'hFFFF_FFFF, 13'h0040, 32'h0000_0000},  // R12
    '{13'h0000, 32'h0000_14BF, 13'h0000, 32'h0000_54BF}   // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic pulse(input logic [5:0] e, input logic rw, input logic [4:0] idx, input logic mw);
    @(negedge clk_i);
    err_evt_i = e; reg_wr_i = rw; reg_idx_i = idx; mem_wr_i = mw;
    @(negedge clk_i);
    err_evt_i = '0; reg_wr_i = 1'b0; mem_wr_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(13'h000, d); chk("R1 ctrl", d, 32'h0000_4000);
    rd(13'h004, d); chk("R1 err", d, 32'h0);
    rd(13'h01C, d); chk("R1 diag", d, 32'h0000_4804);
    rd(13'h028, d); chk("R1 id", d, 32'h0000_009A);
    rd(13'h014, d); chk("R1 rop", d, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    chk("R1 run", {31'h0, run_o}, 32'h0);

    for (int i = 0; i < 11; i++) begin
      wr(VECS[i].wa, VECS[i].wd);
      rd(VECS[i].ra, d);
      chk($sformatf("R2/R10/R12 vector %0d", i), d, VECS[i].ex);
    end
    chk("R2 run_o", {31'h0, run_o}, 32'h1);

    // R3 live status bits
    busy_i = 1'b1; q_empty_i = 1'b0;
    rd(13'h000, d); chk("R3 busy/empty", d, 32'h0000_94BF);
    busy_i = 1'b0; q_empty_i = 1'b1;

    // R4 capture with mask
    pulse(6'b000101, 1'b0, 5'd0, 1'b0);
    rd(13'h004, d); chk("R4 capture", d, 32'h0000_0085);
    chk("R6 irq high", {31'h0, irq_o}, 32'h1);
    wr(13'h000, 32'h0000_1480);
    pulse(6'b001000, 1'b0, 5'd0, 1'b0);
    rd(13'h004, d); chk("R4 masked ignored", d, 32'h0000_0085);

    // R6 interrupt gate
    wr(13'h000, 32'h0000_1400);
    chk("R6 irq gated", {31'h0, irq_o}, 32'h0);
    rd(13'h004, d); chk("R6 err bit7 low", d, 32'h0000_0005);
    wr(13'h000, 32'h0000_14BF);

    // R5 write-one-to-clear and race
    wr(13'h004, 32'h0000_0001);
    rd(13'h004, d); chk("R5 w1c", d, 32'h0000_0084);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 13'h004; wdata_i = 32'h10; err_evt_i = 6'h10;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0; err_evt_i = '0;
    rd(13'h004, d); chk("R5 set wins", d, 32'h0000_0094);
    wr(13'h004, 32'h0000_0014);
    rd(13'h004, d); chk("R5 clear all", d, 32'h0);
    chk("R6 irq low", {31'h0, irq_o}, 32'h0);

    // R7 bank flags
    pulse(6'h0, 1'b1, 5'd9, 1'b0);
    rd(13'h000, d); chk("R7 bank1", d, 32'h0002_54BF);
    pulse(6'h0, 1'b1, 5'd7, 1'b0);
    pulse(6'h0, 1'b1, 5'd31, 1'b0);
    rd(13'h000, d); chk("R7 banks 0,1,3", d, 32'h000B_54BF);

    // R8 clear race and clear
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 13'h000; wdata_i = 32'h0002_14BF; reg_wr_i = 1'b1; reg_idx_i = 5'd10;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0; reg_wr_i = 1'b0;
    rd(13'h000, d); chk("R8 set wins", d, 32'h000B_54BF);
    wr(13'h000, 32'h000F_14BF);
    rd(13'h000, d); chk("R8 w1c", d, 32'h0000_54BF);

    // R9 memory-write flag
    pulse(6'h0, 1'b0, 5'd0, 1'b1);
    rd(13'h000, d); chk("R9 set", d, 32'h0000_5CBF);
    wr(13'h000, 32'h0000_1CBF);
    rd(13'h000, d); chk("R9 w1c", d, 32'h0000_54BF);

    // R11 soft reset
    pulse(6'h02, 1'b1, 5'd0, 1'b1);
    rd(13'h000, d); chk("R11 pre ctrl", d, 32'h0001_5CBF);
    wr(13'h030, 32'h0000_0001);
    rd(13'h000, d); chk("R11 ctrl", d, 32'h0000_44BF);
    chk("R11 run", {31'h0, run_o}, 32'h0);
    rd(13'h004, d); chk("R11 err", d, 32'h0);
    rd(13'h01C, d); chk("R11 diag", d, 32'h0000_4804);
    rd(13'h010, d); chk("R11 pmask kept", d, 32'h0000_00FF);
    rd(13'h030, d); chk("R11 read zero", d, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule